// File: doc/BRIEF.md
# Indirect Branch Target Predictor with Speculative History

This block guesses where an indirect branch will jump. It keeps a small two-way set-associative table of targets. Each set is chosen by mixing the aligned branch address with a speculative global history of recent conditional-branch outcomes. A fetch stage presents a branch address and gets back, one cycle later, a hit flag, a predicted target and a snapshot of the history as it stood at lookup time. The snapshot travels with the branch down the pipeline.

The history moves ahead speculatively. Every predicted conditional outcome is shifted in as it is made. When the pipeline learns that it went wrong, it hands a snapshot back. A wrong-path flush restores the history exactly to that snapshot. A direction mispredict rebuilds the history from the snapshot plus the true outcome. When an indirect target was wrong, the resolving stage writes the correct target. The set for that write comes from the snapshot taken at lookup time, not from the live history, so the write lands in the set the lookup read.

Top module: `itp_top`

## Requirements
- R1: While `rst` is high at a clock edge, the history, every table entry's valid state and `pred_valid` are cleared; after reset `hist_now` reads zero and every lookup misses.
- R2: A direction update (`dir_valid`) shifts the history left by one bit and places `dir_taken` in bit 0. A not-taken outcome shifts in a zero. The result is kept to `GHR_W` bits, so the top bit falls off.
- R3: A lookup presented in cycle t gives `pred_valid`=1 in cycle t+1, together with `pred_hit`, `pred_target` and `pred_ckpt`. `pred_target` is zero on a miss. `pred_ckpt` is the history from before any history write in cycle t.
- R4: A squash loads `squash_ckpt` into the history exactly. It wins over a same-cycle repair and a same-cycle direction update.
- R5: A repair sets the history to (`repair_ckpt` shifted left by one, with `repair_taken` in bit 0), kept to `GHR_W` bits. It wins over a same-cycle direction update.
- R6: The set index is bits [IDX_W-1:0] of ((pc >> SHIFT) XOR history), where IDX_W = log2(SETS). The tag is pc bits [SHIFT+IDX_W +: TAG_W]. A hit needs a valid entry in the indexed set whose tag equals the tag of the pc.
- R7: A target fix (`fix_valid`) picks its set from `fix_pc` and `fix_ckpt`. The live history plays no part.
- R8: If the fixed branch's tag already sits in the indexed set, only that entry's target is overwritten and the other way keeps its contents.
- R9: On a fix that misses, an invalid way is filled, way 0 before way 1. If both ways are valid, the least recently written way is replaced. The way just written becomes the most recently written.
- R10: A lookup in the same cycle as a fix to the same set sees the table contents from before that fix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_valid | input | 1 | Request a target prediction |
| lookup_pc | input | PC_W | Address of the indirect branch |
| dir_valid | input | 1 | A conditional outcome was predicted |
| dir_taken | input | 1 | Predicted outcome, 1 = taken |
| squash_valid | input | 1 | Restore history after a wrong-path flush |
| squash_ckpt | input | GHR_W | Snapshot to restore |
| repair_valid | input | 1 | Rebuild history after a direction mispredict |
| repair_ckpt | input | GHR_W | Snapshot taken before the mispredicted branch |
| repair_taken | input | 1 | Actual outcome of that branch |
| fix_valid | input | 1 | Write a corrected target |
| fix_pc | input | PC_W | Address of the mispredicted indirect branch |
| fix_ckpt | input | GHR_W | Snapshot returned with that branch's prediction |
| fix_target | input | TGT_W | Correct target |
| pred_valid | output | 1 | Prediction result valid (registered) |
| pred_hit | output | 1 | Table hit |
| pred_target | output | TGT_W | Predicted target, zero on a miss |
| pred_ckpt | output | GHR_W | History snapshot from the lookup cycle |
| hist_now | output | GHR_W | Current speculative history |

## Verification
The assertions assume that each control strobe is one cycle wide and that nothing other than the three history controls changes the history. Squash, repair and direction may arrive together, and the checks encode the priority among them. The stimulus drives every input half a cycle away from the sampling edge. It sets the live history to a known value with a squash before each table access, so that every expected set index can be worked out by hand. All table traffic uses a handful of hand-picked sets, so the way choice and replacement order within a set are fully determined.

// File: rtl/itp_pkg.sv
package itp_pkg;
  // Operation applied to the speculative history in a cycle
  typedef enum logic [1:0] {
    HOP_HOLD   = 2'd0,
    HOP_SHIFT  = 2'd1,
    HOP_LOAD   = 2'd2,
    HOP_REPAIR = 2'd3
  } hist_op_e;
endpackage

// File: rtl/itp_history.sv
module itp_history
  import itp_pkg::*;
#(
  parameter int GHR_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  hist_op_e         op,
  input  logic             bit_in,
  input  logic [GHR_W-1:0] ckpt,
  output logic [GHR_W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
    end else begin
      case (op)
        HOP_SHIFT:  hist <= {hist[GHR_W-2:0], bit_in};
        HOP_LOAD:   hist <= ckpt;
        HOP_REPAIR: hist <= {ckpt[GHR_W-2:0], bit_in};
        default:    hist <= hist;
      endcase
    end
  end
endmodule

// File: rtl/itp_hash.sv
module itp_hash #(
  parameter int PC_W  = 32,
  parameter int GHR_W = 13,
  parameter int SHIFT = 2,
  parameter int IDX_W = 6,
  parameter int TAG_W = 16
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [GHR_W-1:0] ghr,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);
  logic [IDX_W-1:0] ghr_fit;
  logic             unused_bits;

  generate
    if (GHR_W >= IDX_W) begin : g_trunc
      assign ghr_fit = ghr[IDX_W-1:0];
    end else begin : g_pad
      assign ghr_fit = {{(IDX_W-GHR_W){1'b0}}, ghr};
    end
  endgenerate

  assign idx = pc[SHIFT +: IDX_W] ^ ghr_fit;
  assign tag = pc[SHIFT+IDX_W +: TAG_W];
  assign unused_bits = ^{pc, ghr};
endmodule

// File: rtl/itp_way.sv
module itp_way #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 16,
  parameter int TGT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vld,
  output logic [TAG_W-1:0] rd_tag,
  output logic [TGT_W-1:0] rd_tgt,
  input  logic [IDX_W-1:0] wr_idx,
  output logic             wr_vld,
  output logic [TAG_W-1:0] wr_cur_tag,
  input  logic             we,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TGT_W-1:0] wr_tgt
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] vld;
  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [TGT_W-1:0] tgt_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else if (we) begin
      vld[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[wr_idx] <= wr_tag;
      tgt_mem[wr_idx] <= wr_tgt;
    end
  end

  assign rd_vld     = vld[rd_idx];
  assign rd_tag     = tag_mem[rd_idx];
  assign rd_tgt     = tgt_mem[rd_idx];
  assign wr_vld     = vld[wr_idx];
  assign wr_cur_tag = tag_mem[wr_idx];
endmodule

// File: rtl/itp_top.sv
module itp_top
  import itp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int TGT_W = 32,
  parameter int GHR_W = 13,
  parameter int SETS  = 64,
  parameter int TAG_W = 16,
  parameter int SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lookup_valid,
  input  logic [PC_W-1:0]  lookup_pc,
  input  logic             dir_valid,
  input  logic             dir_taken,
  input  logic             squash_valid,
  input  logic [GHR_W-1:0] squash_ckpt,
  input  logic             repair_valid,
  input  logic [GHR_W-1:0] repair_ckpt,
  input  logic             repair_taken,
  input  logic             fix_valid,
  input  logic [PC_W-1:0]  fix_pc,
  input  logic [GHR_W-1:0] fix_ckpt,
  input  logic [TGT_W-1:0] fix_target,
  output logic             pred_valid,
  output logic             pred_hit,
  output logic [TGT_W-1:0] pred_target,
  output logic [GHR_W-1:0] pred_ckpt,
  output logic [GHR_W-1:0] hist_now
);
  localparam int IDX_W = $clog2(SETS);
  localparam int NWAYS = 2;

  generate
    if (SETS != (1 << IDX_W)) begin : g_bad_sets
      $error("SETS must be a power of two");
    end
  endgenerate

  // History control, priority squash > repair > direction
  hist_op_e         h_op;
  logic             h_bit;
  logic [GHR_W-1:0] h_ckpt;

  always_comb begin
    h_op   = HOP_HOLD;
    h_bit  = 1'b0;
    h_ckpt = squash_ckpt;
    if (squash_valid) begin
      h_op = HOP_LOAD;
    end else if (repair_valid) begin
      h_op   = HOP_REPAIR;
      h_ckpt = repair_ckpt;
      h_bit  = repair_taken;
    end else if (dir_valid) begin
      h_op  = HOP_SHIFT;
      h_bit = dir_taken;
    end
  end

  itp_history #(.GHR_W(GHR_W)) u_hist (
    .clk(clk), .rst(rst), .op(h_op), .bit_in(h_bit), .ckpt(h_ckpt), .hist(hist_now)
  );

  // Index and tag for the lookup and the fix ports
  logic [IDX_W-1:0] lk_idx, fx_idx;
  logic [TAG_W-1:0] lk_tag, fx_tag;

  itp_hash #(.PC_W(PC_W), .GHR_W(GHR_W), .SHIFT(SHIFT), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_hash_lk (
    .pc(lookup_pc), .ghr(hist_now), .idx(lk_idx), .tag(lk_tag)
  );

  itp_hash #(.PC_W(PC_W), .GHR_W(GHR_W), .SHIFT(SHIFT), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_hash_fx (
    .pc(fix_pc), .ghr(fix_ckpt), .idx(fx_idx), .tag(fx_tag)
  );

  // Ways
  logic [NWAYS-1:0] rd_vld, wr_vld, way_we, lk_match, fx_match;
  logic [TAG_W-1:0] rd_tag [NWAYS];
  logic [TAG_W-1:0] cur_tag [NWAYS];
  logic [TGT_W-1:0] rd_tgt [NWAYS];
  logic             victim;

  generate
    for (genvar w = 0; w < NWAYS; w++) begin : g_way
      itp_way #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_way (
        .clk(clk), .rst(rst),
        .rd_idx(lk_idx), .rd_vld(rd_vld[w]), .rd_tag(rd_tag[w]), .rd_tgt(rd_tgt[w]),
        .wr_idx(fx_idx), .wr_vld(wr_vld[w]), .wr_cur_tag(cur_tag[w]),
        .we(way_we[w]), .wr_tag(fx_tag), .wr_tgt(fix_target)
      );
      assign lk_match[w] = rd_vld[w] && (rd_tag[w] == lk_tag);
      assign fx_match[w] = wr_vld[w] && (cur_tag[w] == fx_tag);
      assign way_we[w]   = fix_valid && (victim == w[0]);
    end
  endgenerate

  // Replacement: one bit per set naming the least recently written way
  logic [SETS-1:0] lru;

  always_comb begin
    if (fx_match[0])      victim = 1'b0;
    else if (fx_match[1]) victim = 1'b1;
    else if (!wr_vld[0])  victim = 1'b0;
    else if (!wr_vld[1])  victim = 1'b1;
    else                  victim = lru[fx_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lru <= '0;
    end else if (fix_valid) begin
      lru[fx_idx] <= ~victim;
    end
  end

  // Lookup result
  logic             lk_hit;
  logic [TGT_W-1:0] lk_tgt;

  always_comb begin
    lk_hit = 1'b0;
    lk_tgt = '0;
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (lk_match[w]) begin
        lk_hit = 1'b1;
        lk_tgt = rd_tgt[w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid  <= 1'b0;
      pred_hit    <= 1'b0;
      pred_target <= '0;
      pred_ckpt   <= '0;
    end else begin
      pred_valid <= lookup_valid;
      if (lookup_valid) begin
        pred_hit    <= lk_hit;
        pred_target <= lk_tgt;
        pred_ckpt   <= hist_now;
      end
    end
  end
endmodule

// File: rtl/itp_checker.sv
module itp_checker #(
  parameter int GHR_W = 13,
  parameter int TGT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             lookup_valid,
  input logic             dir_valid,
  input logic             dir_taken,
  input logic             squash_valid,
  input logic [GHR_W-1:0] squash_ckpt,
  input logic             repair_valid,
  input logic [GHR_W-1:0] repair_ckpt,
  input logic             repair_taken,
  input logic             pred_valid,
  input logic             pred_hit,
  input logic [TGT_W-1:0] pred_target,
  input logic [GHR_W-1:0] pred_ckpt,
  input logic [GHR_W-1:0] hist_now
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (hist_now == '0) && !pred_valid); // R1

  AST_DIR_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (dir_valid && !squash_valid && !repair_valid) |=>
      hist_now == {$past(hist_now[GHR_W-2:0]), $past(dir_taken)}); // R2

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!dir_valid && !squash_valid && !repair_valid) |=> $stable(hist_now)); // R2

  AST_PRED_TIMING: assert property (@(posedge clk) disable iff (rst)
    lookup_valid |=> pred_valid && (pred_ckpt == $past(hist_now))); // R3

  AST_PRED_IDLE: assert property (@(posedge clk) disable iff (rst)
    !lookup_valid |=> !pred_valid); // R3

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && !pred_hit) |-> (pred_target == '0)); // R3

  AST_SQUASH_LOAD: assert property (@(posedge clk) disable iff (rst)
    squash_valid |=> hist_now == $past(squash_ckpt)); // R4

  AST_REPAIR_LOAD: assert property (@(posedge clk) disable iff (rst)
    (repair_valid && !squash_valid) |=>
      hist_now == {$past(repair_ckpt[GHR_W-2:0]), $past(repair_taken)}); // R5
endmodule

bind itp_top itp_checker #(.GHR_W(GHR_W), .TGT_W(TGT_W)) u_itp_checker (
  .clk(clk), .rst(rst), .lookup_valid(lookup_valid),
  .dir_valid(dir_valid), .dir_taken(dir_taken),
  .squash_valid(squash_valid), .squash_ckpt(squash_ckpt),
  .repair_valid(repair_valid), .repair_ckpt(repair_ckpt), .repair_taken(repair_taken),
  .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_target(pred_target),
  .pred_ckpt(pred_ckpt), .hist_now(hist_now)
);

// File: tb/itp_top_bench.sv
module itp_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W  = 32;
  localparam int TGT_W = 32;
  localparam int GHR_W = 13;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             lookup_valid = 1'b0;
  logic [PC_W-1:0]  lookup_pc = '0;
  logic             dir_valid = 1'b0;
  logic             dir_taken = 1'b0;
  logic             squash_valid = 1'b0;
  logic [GHR_W-1:0] squash_ckpt = '0;
  logic             repair_valid = 1'b0;
  logic [GHR_W-1:0] repair_ckpt = '0;
  logic             repair_taken = 1'b0;
  logic             fix_valid = 1'b0;
  logic [PC_W-1:0]  fix_pc = '0;
  logic [GHR_W-1:0] fix_ckpt = '0;
  logic [TGT_W-1:0] fix_target = '0;
  logic             pred_valid, pred_hit;
  logic [TGT_W-1:0] pred_target;
  logic [GHR_W-1:0] pred_ckpt, hist_now;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  itp_top u_itp_top (
    .clk(clk), .rst(rst),
    .lookup_valid(lookup_valid), .lookup_pc(lookup_pc),
    .dir_valid(dir_valid), .dir_taken(dir_taken),
    .squash_valid(squash_valid), .squash_ckpt(squash_ckpt),
    .repair_valid(repair_valid), .repair_ckpt(repair_ckpt), .repair_taken(repair_taken),
    .fix_valid(fix_valid), .fix_pc(fix_pc), .fix_ckpt(fix_ckpt), .fix_target(fix_target),
    .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_target(pred_target),
    .pred_ckpt(pred_ckpt), .hist_now(hist_now)
  );

  function automatic logic [PC_W-1:0] mkpc(int set, int tag);
    return PC_W'((tag << 8) | (set << 2)); // SHIFT=2, IDX_W=6
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // All stimulus tasks start and end at a falling edge
  task automatic set_hist(logic [GHR_W-1:0] h);
    squash_valid = 1'b1; squash_ckpt = h;
    @(negedge clk);
    squash_valid = 1'b0;
  endtask

  task automatic dir(logic t);
    dir_valid = 1'b1; dir_taken = t;
    @(negedge clk);
    dir_valid = 1'b0;
  endtask

  task automatic lookup(logic [PC_W-1:0] pc);
    lookup_valid = 1'b1; lookup_pc = pc;
    @(negedge clk);
    lookup_valid = 1'b0;
  endtask

  task automatic fix(logic [PC_W-1:0] pc, logic [GHR_W-1:0] ck, logic [TGT_W-1:0] t);
    fix_valid = 1'b1; fix_pc = pc; fix_ckpt = ck; fix_target = t;
    @(negedge clk);
    fix_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 hist after reset", hist_now, 0);
    check("R1 pred_valid after reset", pred_valid, 0);
    lookup(32'h0000_1234);
    check("R3 pred_valid", pred_valid, 1);
    check("R1 miss after reset", pred_hit, 0);
    check("R3 miss target zero", pred_target, 0);
    check("R3 ckpt", pred_ckpt, 0);
  endtask

  task automatic t_shift();
    set_hist(0);
    dir(1); dir(0); dir(1);
    check("R2 pattern 101", hist_now, 13'h5);
    lookup(32'h40);
    check("R3 ckpt follows history", pred_ckpt, 13'h5);
    for (int i = 0; i < 16; i++) dir(1);
    check("R2 masked to width", hist_now, 13'h1FFF);
    dir(0);
    check("R2 not-taken shifts zero", hist_now, 13'h1FFE);
  endtask

  task automatic t_lookup_old();
    set_hist(13'h0F0);
    lookup_valid = 1'b1; lookup_pc = 32'h80;
    dir_valid = 1'b1; dir_taken = 1'b1;
    @(negedge clk);
    lookup_valid = 1'b0; dir_valid = 1'b0;
    check("R3 ckpt before same-cycle update", pred_ckpt, 13'h0F0);
    check("R2 update alongside lookup", hist_now, 13'h1E1);
  endtask

  task automatic t_squash();
    set_hist(13'h100);
    squash_valid = 1'b1; squash_ckpt = 13'h0AB;
    repair_valid = 1'b1; repair_ckpt = 13'h1FF; repair_taken = 1'b1;
    dir_valid = 1'b1; dir_taken = 1'b1;
    @(negedge clk);
    squash_valid = 1'b0; repair_valid = 1'b0; dir_valid = 1'b0;
    check("R4 squash wins and restores", hist_now, 13'h0AB);
  endtask

  task automatic t_repair();
    set_hist(13'h003);
    repair_valid = 1'b1; repair_ckpt = 13'h1ABC; repair_taken = 1'b1;
    dir_valid = 1'b1; dir_taken = 1'b0;
    @(negedge clk);
    repair_valid = 1'b0; dir_valid = 1'b0;
    check("R5 repair over direction", hist_now, 13'h1579);
    repair_valid = 1'b1; repair_ckpt = 13'h1000; repair_taken = 1'b0;
    @(negedge clk);
    repair_valid = 1'b0;
    check("R5 repair masked", hist_now, 13'h0000);
  endtask

  task automatic t_index();
    set_hist(0);
    fix(mkpc(20, 16'hABCD), 0, 32'hCAFE_0000);
    lookup(mkpc(20, 16'hABCD));
    check("R6 hit after fix", pred_hit, 1);
    check("R6 target after fix", pred_target, 32'hCAFE_0000);
    lookup(mkpc(20, 16'hABCE));
    check("R6 other tag misses", pred_hit, 0);
    set_hist(13'h005);
    lookup(mkpc(20, 16'hABCD));
    check("R6 history moves the set", pred_hit, 0);
    set_hist(13'h040);
    lookup(mkpc(20, 16'hABCD));
    check("R6 history bits above index ignored", pred_hit, 1);
  endtask

  task automatic t_ckpt_write();
    set_hist(13'h003);
    fix(mkpc(40, 16'h1111), 13'h005, 32'h1234_5678);
    set_hist(13'h005);
    lookup(mkpc(40, 16'h1111));
    check("R7 fix used checkpoint set", pred_hit, 1);
    check("R7 fix target", pred_target, 32'h1234_5678);
    set_hist(13'h003);
    lookup(mkpc(40, 16'h1111));
    check("R7 live history set untouched", pred_hit, 0);
  endtask

  task automatic t_replace();
    set_hist(0);
    fix(mkpc(9, 1), 0, 32'hA0);
    fix(mkpc(9, 2), 0, 32'hB0);
    fix(mkpc(9, 1), 0, 32'hA1);
    lookup(mkpc(9, 1));
    check("R8 overwrite target", pred_target, 32'hA1);
    lookup(mkpc(9, 2));
    check("R8 other way kept", pred_target, 32'hB0);
    fix(mkpc(9, 3), 0, 32'hC0);
    lookup(mkpc(9, 3));
    check("R9 new entry hit", pred_target, 32'hC0);
    lookup(mkpc(9, 2));
    check("R9 LRU way evicted", pred_hit, 0);
    lookup(mkpc(9, 1));
    check("R9 recent way kept", pred_target, 32'hA1);
    fix(mkpc(9, 2), 0, 32'hB1);
    lookup(mkpc(9, 1));
    check("R9 LRU flips after write", pred_hit, 0);
  endtask

  task automatic t_read_before_write();
    set_hist(0);
    lookup_valid = 1'b1; lookup_pc = mkpc(30, 7);
    fix_valid = 1'b1; fix_pc = mkpc(30, 7); fix_ckpt = 0; fix_target = 32'hD0;
    @(negedge clk);
    lookup_valid = 1'b0; fix_valid = 1'b0;
    check("R10 same-cycle lookup sees old", pred_hit, 0);
    lookup(mkpc(30, 7));
    check("R10 next lookup sees fix", pred_target, 32'hD0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_shift();
    t_lookup_old();
    t_squash();
    t_repair();
    t_index();
    t_ckpt_write();
    t_replace();
    t_read_before_write();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule